// File: doc/BRIEF.md
# Mode-Selectable SPI Master Shifter

This block is a full-duplex serial master for one attached slave. A single start pulse sends one frame. The frame's bits leave on `mosi` while the same number of bits arrive on `miso`. The serial clock `sck` is made from the system clock by a divider.

For each frame, the caller chooses four settings:
- the idle level of the clock;
- whether data is captured on the leading or the trailing edge of each clock pulse;
- the frame length, from 4 to 16 bits;
- the divider value.

All four are taken from the configuration inputs in the cycle the start is accepted. They stay fixed until that frame ends.

The transmit word is sent most significant bit first, counting only the active frame length. The received bits are returned right-aligned in `rx_word`. An active-low select output frames the transfer; a parameter can remove it. `busy` covers the whole transfer. A one-cycle `done` marks the end, at which point `rx_word` holds the new frame.

Top module: `spi_mode_master`

## Requirements
- R1: After reset, `sck` is 0, `ss_n` is 1, `busy` and `done` are 0 and `rx_word` is 0. The settings in force after reset are an 8-bit frame, idle-low clock and leading-edge capture.
- R2: While no transfer is running, `sck` rests at the idle level of the last accepted transfer: `cfg_pol`=0 gives low, `cfg_pol`=1 gives high.
- R3: With `cfg_pha`=0, the first data bit is on `mosi` when `ss_n` falls, which is one half period before the first `sck` edge. Data is captured on every leading edge (away from idle) and `mosi` changes on trailing edges.
- R4: With `cfg_pha`=1, `mosi` changes on leading edges and data is captured on every trailing edge (back to idle), starting with the second edge of the frame.
- R5: The frame length L is `cfg_len`, clamped to the range 4..16. Exactly 2·L `sck` edges occur per transfer. Bits `tx_word[L-1:0]` are sent MSB first, and `tx_word` bits at L and above have no effect.
- R6: Every `sck` half period, including the gap from the start to the first edge, lasts `cfg_div`+1 system clocks.
- R7: `done` is high for exactly one clock. It is high in the cycle after the final `sck` edge, with `sck` back at idle. The cycle count from start acceptance to `done` is 2·L·(`cfg_div`+1)+1. `busy` is high from acceptance through the `done` cycle.
- R8: `ss_n` is low only while `sck` is being clocked and is high when `done` is high.
- R9: A start while `busy` is high is ignored: no extra transfer follows. Configuration inputs and `tx_word` are sampled only when a start is accepted.
- R10: `rx_word` holds the L bits sampled from `miso` in arrival order, the first bit at position L-1, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one frame; accepted only when idle |
| cfg_pol | input | 1 | Clock idle level |
| cfg_pha | input | 1 | 0: capture on leading edges, 1: capture on trailing edges |
| cfg_len | input | 5 | Frame length in bits, clamped to 4..16 |
| cfg_div | input | 8 | Half period of `sck` minus one, in system clocks |
| tx_word | input | 16 | Data to send; low L bits used |
| rx_word | output | 16 | Received frame, zero-extended |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
A bench slave reacts to the select line and clock edges the way a peripheral would. It records what arrives on `mosi` and serves its own word on `miso`, so each direction of a frame is checked on its own.

The stimulus covers:
- All four polarity/phase pairings at short, odd, middle and full lengths. A mistake in which edge is used for capture corrupts the data in one phase only.
- Several divider values, which show whether the half-period count is off by one.
- Lengths below 4 and above 16, which exercise the clamping.
- Transmit words with upper bits set, which catch leakage of bits outside the frame.
- A start pulse during a running transfer, carrying different settings and data. It shows whether the running frame is disturbed or a second transfer begins.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

    parameter int unsigned FRAME_MAX   = 16;
    parameter int unsigned FRAME_MIN   = 4;
    parameter int unsigned FRAME_RESET = 8;
    parameter int unsigned LEN_W       = $clog2(FRAME_MAX + 1);
    parameter int unsigned DIV_W       = 8;
    parameter int unsigned EDGE_W      = LEN_W + 1;

    typedef struct packed {
        logic              pol;
        logic              pha;
        logic [LEN_W-1:0]  len;
        logic [DIV_W-1:0]  div;
    } xfer_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } ctl_state_t;

    localparam xfer_cfg_t CFG_RESET = '{
        pol: 1'b0,
        pha: 1'b0,
        len: LEN_W'(FRAME_RESET),
        div: '0
    };

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] req);
        if (req < LEN_W'(FRAME_MIN))      return LEN_W'(FRAME_MIN);
        else if (req > LEN_W'(FRAME_MAX)) return LEN_W'(FRAME_MAX);
        else                              return req;
    endfunction

endpackage

// File: rtl/spi_mm_sckgen.sv
module spi_mm_sckgen
    import spi_mm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             idle_lvl,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             sck_q;

    assign tick = run && (cnt_q == div);
    assign sck  = sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (load) begin
            cnt_q <= '0;
            sck_q <= idle_lvl;
        end else if (run) begin
            if (tick) begin
                cnt_q <= '0;
                sck_q <= ~sck_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= div));

endmodule

// File: rtl/spi_mm_edgeseq.sv
module spi_mm_edgeseq
    import spi_mm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             tick,
    input  logic             pha,
    input  logic [LEN_W-1:0] len,
    output logic             shift_en,
    output logic             cap_en,
    output logic             last_edge
);
    logic [EDGE_W-1:0] ecnt_q;
    logic [EDGE_W-1:0] enext;
    logic              odd;
    logic              is_last;

    always_comb begin
        enext     = ecnt_q + 1'b1;
        odd       = enext[0];
        is_last   = (enext == {len, 1'b0});
        last_edge = tick && is_last;
        cap_en    = tick && (odd ^ pha);
        if (pha)
            shift_en = tick && odd && (enext != EDGE_W'(1));
        else
            shift_en = tick && !odd && !is_last;
    end

    always_ff @(posedge clk) begin
        if (rst || load) ecnt_q <= '0;
        else if (tick)   ecnt_q <= enext;
    end

    // R5
    edge_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ecnt_q <= {len, 1'b0});

endmodule

// File: rtl/spi_mm_shifter.sv
module spi_mm_shifter
    import spi_mm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [FRAME_MAX-1:0] tx_word,
    input  logic [LEN_W-1:0]     len,
    input  logic                 shift_en,
    input  logic                 cap_en,
    input  logic                 miso,
    output logic                 mosi,
    output logic [FRAME_MAX-1:0] rx_next
);
    logic [FRAME_MAX-1:0] tx_sh;
    logic [FRAME_MAX-1:0] rx_sh;

    assign mosi    = tx_sh[FRAME_MAX-1];
    assign rx_next = cap_en ? {rx_sh[FRAME_MAX-2:0], miso} : rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else if (load) begin
            tx_sh <= tx_word << (LEN_W'(FRAME_MAX) - len);
            rx_sh <= '0;
        end else begin
            if (shift_en) tx_sh <= {tx_sh[FRAME_MAX-2:0], 1'b0};
            rx_sh <= rx_next;
        end
    end

endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
    import spi_mm_pkg::*;
#(
    parameter bit USE_SS = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 cfg_pol,
    input  logic                 cfg_pha,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic [FRAME_MAX-1:0] tx_word,
    output logic [FRAME_MAX-1:0] rx_word,
    output logic                 busy,
    output logic                 done,
    output logic                 sck,
    output logic                 mosi,
    input  logic                 miso,
    output logic                 ss_n
);
    ctl_state_t           state_q;
    xfer_cfg_t            cfg_q;
    logic [FRAME_MAX-1:0] rx_q;
    logic                 accept;
    logic                 tick;
    logic                 shift_en;
    logic                 cap_en;
    logic                 last_edge;
    logic [LEN_W-1:0]     len_new;
    logic [FRAME_MAX-1:0] rx_next;

    assign accept  = start && (state_q == ST_IDLE);
    assign len_new = clamp_len(cfg_len);
    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_FIN);
    assign rx_word = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= CFG_RESET;
            rx_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    cfg_q   <= '{pol: cfg_pol, pha: cfg_pha, len: len_new, div: cfg_div};
                    state_q <= ST_RUN;
                end
                ST_RUN: if (last_edge) begin
                    rx_q    <= rx_next;
                    state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    spi_mm_sckgen u_sck (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .idle_lvl (cfg_pol),
        .run      (state_q == ST_RUN),
        .div      (cfg_q.div),
        .sck      (sck),
        .tick     (tick)
    );

    spi_mm_edgeseq u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .tick      (tick),
        .pha       (cfg_q.pha),
        .len       (cfg_q.len),
        .shift_en  (shift_en),
        .cap_en    (cap_en),
        .last_edge (last_edge)
    );

    spi_mm_shifter u_shf (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .tx_word  (tx_word),
        .len      (len_new),
        .shift_en (shift_en),
        .cap_en   (cap_en),
        .miso     (miso),
        .mosi     (mosi),
        .rx_next  (rx_next)
    );

    generate
        if (USE_SS) begin : g_ss
            logic ss_q;
            always_ff @(posedge clk) begin
                if (rst)            ss_q <= 1'b1;
                else if (accept)    ss_q <= 1'b0;
                else if (last_edge) ss_q <= 1'b1;
            end
            assign ss_n = ss_q;
        end else begin : g_no_ss
            assign ss_n = 1'b1;
        end
    endgenerate

    // Observation of sck spacing for the half-period assertion
    logic             sck_prev;
    logic [DIV_W:0]   gap_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
            gap_q    <= '0;
        end else begin
            sck_prev <= sck;
            if (accept)    gap_q <= '0;
            else if (busy) gap_q <= (sck != sck_prev) ? (DIV_W+1)'(1) : gap_q + 1'b1;
        end
    end

    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (sck == cfg_q.pol));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (sck == cfg_q.pol));

    // R8
    ss_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ss_n);

    // R8
    ss_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !ss_n |-> busy);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));

    // R3
    mosi_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $stable(sck)) |-> $stable(mosi));

    // R6
    half_period_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (sck != sck_prev)) |-> (gap_q == ({1'b0, cfg_q.div} + 1'b1)));

endmodule

// File: tb/sim_spi_mode_master.sv
module sim_spi_mode_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cfg_pol = 1'b0;
    logic        cfg_pha = 1'b0;
    logic [4:0]  cfg_len = 5'd8;
    logic [7:0]  cfg_div = 8'd0;
    logic [15:0] tx_word = 16'h0;
    logic [15:0] rx_word;
    logic        busy, done, sck, mosi, ss_n;
    logic        miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_mode_master u0 (
        .clk(clk), .rst(rst), .start(start), .cfg_pol(cfg_pol), .cfg_pha(cfg_pha),
        .cfg_len(cfg_len), .cfg_div(cfg_div), .tx_word(tx_word), .rx_word(rx_word),
        .busy(busy), .done(done), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    typedef struct {
        logic [15:0] rx;
        logic [15:0] mo;
        int          edges;
        int          scyc;
        int          cycles;
        bit          pol;
    } exp_t;
    exp_t q[$];

    int  checks = 0;
    int  fails  = 0;
    int  cyc    = 0;
    bit  ended  = 0;

    // slave model settings, written by the driver
    bit          s_pol, s_pha;
    int          s_len, s_div;
    logic [15:0] s_word, s_tx;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) cyc++;

    // slave model and result monitor
    bit          active, prev_sck, prev_ss, prev_done, gap_bad;
    int          bi, gap, nedge;
    logic [15:0] scap;
    always @(negedge clk) begin
        if (rst) begin
            active = 0; prev_sck = 0; prev_ss = 1; prev_done = 0;
            miso = 1'b0;
        end else begin
            if (prev_ss && !ss_n) begin
                active = 1; gap = 0; nedge = 0; gap_bad = 0; scap = '0;
                if (!s_pha) begin
                    miso = s_word[s_len-1];
                    bi   = s_len - 2;
                    // R3: first bit present before the first edge
                    chk(mosi == s_tx[s_len-1], "R3", "first mosi bit", mosi, s_tx[s_len-1]);
                end else begin
                    bi = s_len - 1;
                end
            end else if (active) begin
                gap++;
                if (sck != prev_sck) begin
                    nedge++;
                    if (gap != s_div + 1) gap_bad = 1;
                    gap = 0;
                    if ((sck != s_pol) ^ s_pha) begin
                        scap = {scap[14:0], mosi};
                    end else if (bi >= 0) begin
                        miso = s_word[bi];
                        bi--;
                    end
                end
            end

            if (prev_done && done)
                chk(0, "R7", "done wider than one cycle", 1, 0);
            if (done) begin
                if (q.size() == 0) begin
                    chk(0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    // R10
                    chk(rx_word == e.rx, "R10", "rx_word", rx_word, e.rx);
                    // R5 R3 R4: data the slave saw, MSB first, masked to the frame
                    chk(scap == e.mo, "R5", "slave received", scap, e.mo);
                    chk(nedge == e.edges, "R5", "sck edge count", nedge, e.edges);
                    // R6
                    chk(!gap_bad, "R6", "half period length", gap_bad, 0);
                    // R7
                    chk(cyc - e.scyc == e.cycles, "R7", "cycles to done", cyc - e.scyc, e.cycles);
                    chk(sck == e.pol, "R7", "sck idle at done", sck, e.pol);
                    chk(busy == 1'b1, "R7", "busy during done", busy, 1);
                    // R8
                    chk(ss_n == 1'b1, "R8", "ss_n at done", ss_n, 1);
                end
                active = 0;
            end
            prev_done = done;
            prev_sck  = sck;
            prev_ss   = ss_n;
        end
    end

    task automatic xfer(input logic [15:0] tx, input logic [15:0] sw, input int len_in,
                        input bit pol, input bit pha, input int dv, input bit poke);
        int   eff;
        exp_t e;
        logic [15:0] mask;
        eff  = (len_in < 4) ? 4 : (len_in > 16) ? 16 : len_in;
        mask = 16'hFFFF >> (16 - eff);
        @(negedge clk);
        while (busy) @(negedge clk);
        s_pol = pol; s_pha = pha; s_len = eff; s_div = dv; s_word = sw; s_tx = tx;
        cfg_pol = pol; cfg_pha = pha; cfg_len = 5'(len_in); cfg_div = 8'(dv); tx_word = tx;
        e.rx = sw & mask; e.mo = tx & mask; e.edges = 2 * eff;
        e.scyc = cyc; e.cycles = 2 * eff * (dv + 1) + 1; e.pol = pol;
        q.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            // R9: start while busy with different settings and data
            cfg_pol = ~pol; cfg_pha = ~pha; cfg_len = 5'd5; cfg_div = 8'd0; tx_word = ~tx;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(sck == 1'b0, "R1", "sck after reset", sck, 0);
        chk(ss_n == 1'b1, "R1", "ss_n after reset", ss_n, 1);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(rx_word == 16'h0, "R1", "rx_word after reset", rx_word, 0);

        xfer(16'h00A5, 16'h003C, 8, 0, 0, 1, 0);
        xfer(16'h005A, 16'h00C3, 8, 0, 1, 0, 0);
        xfer(16'hF9E1, 16'h0B72, 12, 1, 0, 2, 0);
        // R2: clock rests high after an idle-high transfer
        repeat (6) @(negedge clk);
        chk(sck == 1'b1, "R2", "sck idle high", sck, 1);
        xfer(16'h8001, 16'hBEEF, 16, 1, 1, 3, 0);
        // R5: clamping and ignored upper bits
        xfer(16'hFFF5, 16'h000A, 3, 0, 0, 0, 0);
        xfer(16'h1234, 16'hCAFE, 31, 1, 1, 1, 0);
        xfer(16'hABC6, 16'h0009, 4, 1, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk(sck == 1'b1, "R2", "sck idle high after short frame", sck, 1);

        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                int ln;
                ln = (k == 0) ? 4 : (k == 1) ? 7 : (k == 2) ? 13 : 16;
                // R3 R4 all four mode pairings
                xfer(16'(16'h9C3B * (m + 3) + k), 16'(16'h5A71 ^ (k * 16'h1111 + m)),
                     ln, m[1], m[0], (m + k) % 3, 0);
            end
        end
        repeat (4) @(negedge clk);
        chk(sck == 1'b1, "R2", "sck idle high after mode 3", sck, 1);

        // R9: a start while busy must not disturb or add a transfer
        xfer(16'h00C9, 16'h0036, 8, 0, 1, 2, 1);
        repeat (8) @(negedge clk);
        chk(busy == 1'b0, "R9", "no second transfer", busy, 0);
        chk(sck == 1'b0, "R9", "idle level kept from accepted cfg", sck, 0);
        chk(q.size() == 0, "R9", "scoreboard drained", q.size(), 0);

        summary();
    end
endmodule